// File: doc/BRIEF.md
# Endian-selectable byte-addressed data memory

This block is a synchronous data store of 32-bit words in which every byte has its own address. Word `n` occupies byte addresses `4n` to `4n+3`. It performs four kinds of access: full-word load, full-word store, single-byte load and single-byte store. A byte load is widened to 32 bits by sign extension.

A select input chooses the byte numbering inside each word on every access. When the select is low, byte offset 0 is the least significant byte. When it is high, byte offset 0 is the most significant byte. The word address of any word is the same under both numberings. Only the choice of byte lane depends on the select, so one stored word can be read back in either numbering.

The storage is split into four byte-wide banks so that it maps onto block RAM with byte write enables. A load result appears on the output one clock after the access and stays there until the next load. A word access whose two low address bits are not zero raises a flag and writes nothing.

Top module: `endian_dmem`

## Requirements
- R1: A word store to byte address 4n followed by a word load from 4n returns the stored 32-bit value; the lowest word (address 0) and the highest word (address 4*(2^(ADDR_W-2)-1)) both behave this way.
- R2: With `big_end`=0, a byte load from offset k (address bits [1:0]) returns bits [8k+7:8k] of the stored word.
- R3: With `big_end`=1, a byte load from offset k returns bits [31-8k:24-8k] of the stored word. After storing 0x23456789 at address 0, a byte load from address 1 gives 0x00000045 with `big_end`=1 and 0x00000067 with `big_end`=0.
- R4: A byte load fills `rd_data[31:8]` with copies of the selected byte's bit 7.
- R5: A byte store writes `wr_data[7:0]` into the lane chosen by the offset and `big_end` (the same lane mapping as R2 and R3). The other three bytes of the word are left unchanged.
- R6: A word access (op 00 or 01) with address bits [1:0] not equal to 0 sets `misalign` in the following cycle. A misaligned word store writes nothing. A misaligned word load returns the word at the address with bits [1:0] cleared. An aligned access or any byte access clears `misalign` in the following cycle.
- R7: While `en`=0, no byte is written and both `rd_data` and `misalign` hold their values.
- R8: `rd_data` changes only in the cycle after an enabled load (op 00 or 10). An enabled store leaves `rd_data` unchanged.
- R9: A synchronous active-high `rst` drives `rd_data` and `misalign` to 0.
- R10: A word stored with either `big_end` value reads back identically as a word under the other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output state |
| en | input | 1 | Access enable |
| op | input | 2 | Access kind: 00 word load, 01 word store, 10 byte load, 11 byte store |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 32 | Store value; byte stores use bits [7:0] |
| big_end | input | 1 | Byte numbering: 0 offset 0 is least significant, 1 offset 0 is most significant |
| rd_data | output | 32 | Load result, valid from the cycle after a load |
| misalign | output | 1 | Set in the cycle after a word access with nonzero low address bits |

## Verification
The assertions assume that `op`, `addr` and `big_end` are stable, known values at every rising edge where `en` is high. They also assume that `rst` is applied for at least one edge before any access. The stimulus changes every input only on falling edges, starting after reset, and loads only from words it has stored before. This keeps the block's uninitialised RAM contents out of every compared result.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_STW = 2'b01,
    OP_LDB = 2'b10,
    OP_STB = 2'b11
  } mem_op_e;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // Physical lane 0 is the least significant byte of the word.
  function automatic logic [1:0] phys_lane(input logic [1:0] ofs, input logic big);
    return big ? ~ofs : ofs;
  endfunction

endpackage

// File: rtl/dmem_lane_ctl.sv
module dmem_lane_ctl
  import dmem_pkg::*;
(
  input  logic              en,
  input  logic [1:0]        op,
  input  logic [1:0]        ofs,
  input  logic              big_end,
  input  logic [WORD_W-1:0] wr_data,
  output logic [LANES-1:0]  lane_we,
  output logic [WORD_W-1:0] lane_wdata,
  output logic [1:0]        lane,
  output logic              is_load,
  output logic              is_byte,
  output logic              bad_align
);

  logic is_store;

  always_comb begin
    is_byte   = (op == OP_LDB) || (op == OP_STB);
    is_store  = (op == OP_STW) || (op == OP_STB);
    is_load   = !is_store;
    lane      = phys_lane(ofs, big_end);
    bad_align = !is_byte && (ofs != 2'b00);
    lane_we   = '0;
    if (en && is_store) begin
      if (is_byte)
        lane_we[lane] = 1'b1;
      else if (!bad_align)
        lane_we = '1;
    end
    lane_wdata = is_byte ? {LANES{wr_data[LANE_W-1:0]}} : wr_data;
  end

endmodule

// File: rtl/dmem_bank.sv
module dmem_bank
  import dmem_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANES-1:0]  lane_we,
  input  logic [WORD_W-1:0] lane_wdata,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word
);

  localparam int DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] ram [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (lane_we[g])
        ram[idx] <= lane_wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (rd_en)
        q <= ram[idx];
    end

    assign rd_word[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/dmem_load_fmt.sv
module dmem_load_fmt
  import dmem_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        lane,
  input  logic              is_byte,
  output logic [WORD_W-1:0] result
);

  logic [LANE_W-1:0] sel;

  always_comb begin
    sel    = word[lane*LANE_W +: LANE_W];
    result = is_byte ? {{(WORD_W-LANE_W){sel[LANE_W-1]}}, sel} : word;
  end

endmodule

// File: rtl/endian_dmem.sv
module endian_dmem
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  input  logic              big_end,
  output logic [31:0]       rd_data,
  output logic              misalign
);

  localparam int IDX_W = ADDR_W - 2;

  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] lane_wdata;
  logic [1:0]        lane;
  logic              is_load, is_byte, bad_align;
  logic [WORD_W-1:0] rd_word;
  logic [1:0]        lane_q;
  logic              is_byte_q;
  logic              mis_q;

  dmem_lane_ctl u_ctl (
    .en         (en),
    .op         (op),
    .ofs        (addr[1:0]),
    .big_end    (big_end),
    .wr_data    (wr_data),
    .lane_we    (lane_we),
    .lane_wdata (lane_wdata),
    .lane       (lane),
    .is_load    (is_load),
    .is_byte    (is_byte),
    .bad_align  (bad_align)
  );

  dmem_bank #(.IDX_W(IDX_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .idx        (addr[ADDR_W-1:2]),
    .lane_we    (lane_we),
    .lane_wdata (lane_wdata),
    .rd_en      (en && is_load),
    .rd_word    (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q    <= '0;
      is_byte_q <= 1'b0;
      mis_q     <= 1'b0;
    end else if (en) begin
      mis_q <= bad_align;
      if (is_load) begin
        lane_q    <= lane;
        is_byte_q <= is_byte;
      end
    end
  end

  dmem_load_fmt u_fmt (
    .word    (rd_word),
    .lane    (lane_q),
    .is_byte (is_byte_q),
    .result  (rd_data)
  );

  assign misalign = mis_q;

endmodule

// File: rtl/endian_dmem_chk.sv
module endian_dmem_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [1:0]        op,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic              big_end,
  input logic [31:0]       rd_data,
  input logic              misalign
);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == 32'h0 && !misalign));

  // R6
  word_misalign_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !op[1] && addr[1:0] != 2'b00) |=> misalign);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(rd_data) && $stable(misalign)));

  // R4
  byte_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op == 2'b10) |=> (rd_data[31:8] == {24{rd_data[7]}}));

  // R8
  store_keeps_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op[0]) |=> $stable(rd_data));

endmodule

bind endian_dmem endian_dmem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .op       (op),
  .addr     (addr),
  .wr_data  (wr_data),
  .big_end  (big_end),
  .rd_data  (rd_data),
  .misalign (misalign)
);

// File: tb/endian_dmem_tb.sv
`timescale 1ns/1ps
module endian_dmem_tb;

  localparam int ADDR_W = 10;
  localparam int NWORDS = 1 << (ADDR_W - 2);
  localparam logic [1:0] LDW = 2'b00, STW = 2'b01, LDB = 2'b10, STB = 2'b11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic [1:0]        op = 2'b00;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wr_data = '0;
  logic              big_end = 1'b0;
  logic [31:0]       rd_data;
  logic              misalign;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] exp_rd;
    logic        exp_mis;
    string       tag;
  } item_t;

  item_t sb_q[$];
  logic [31:0] mdl [NWORDS];
  logic [31:0] last_rd;
  logic        last_mis;

  always #2.5 clk = ~clk;

  endian_dmem #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .op(op), .addr(addr),
    .wr_data(wr_data), .big_end(big_end), .rd_data(rd_data), .misalign(misalign)
  );

  function automatic int lane_of(input logic [1:0] ofs, input logic be);
    return be ? 3 - int'(ofs) : int'(ofs);
  endfunction

  // Driver: drives one access, updates the reference model, queues the expected result.
  task automatic access(input logic [1:0] o, input logic [ADDR_W-1:0] a,
                        input logic [31:0] wd, input logic be, input logic e,
                        input string tag);
    int idx;
    int ln;
    logic [7:0] b;
    idx = int'(a[ADDR_W-1:2]);
    ln  = lane_of(a[1:0], be);
    @(negedge clk);
    en = e; op = o; addr = a; wr_data = wd; big_end = be;
    if (e) begin
      last_mis = !o[1] && (a[1:0] != 2'b00);
      case (o)
        LDW: last_rd = mdl[idx];
        LDB: begin
          b = mdl[idx][ln*8 +: 8];
          last_rd = {{24{b[7]}}, b};
        end
        STW: if (!last_mis) mdl[idx] = wd;
        default: mdl[idx][ln*8 +: 8] = wd[7:0];
      endcase
    end
    @(posedge clk);
    sb_q.push_back('{exp_rd: last_rd, exp_mis: last_mis, tag: tag});
  endtask

  // Monitor: compares queued expectations at the falling edge after each access.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rd_data !== it.exp_rd || misalign !== it.exp_mis) begin
        failures++;
        $display("FAIL %s: rd_data=%h misalign=%b expected rd_data=%h misalign=%b",
                 it.tag, rd_data, misalign, it.exp_rd, it.exp_mis);
      end
    end
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    last_rd = '0;
    last_mis = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (rd_data !== 32'h0 || misalign !== 1'b0) begin
      failures++;
      $display("FAIL R9: rd_data=%h misalign=%b expected 00000000 0", rd_data, misalign);
    end

    // R1 / R2 / R3 / R10: word at address 0, both numberings
    access(STW, 10'd0, 32'h23456789, 1'b0, 1'b1, "R1 store word 0");
    access(LDW, 10'd0, 32'h0, 1'b0, 1'b1, "R1 load word 0");
    access(LDB, 10'd1, 32'h0, 1'b0, 1'b1, "R2 little byte 1 = 67");
    access(LDB, 10'd1, 32'h0, 1'b1, 1'b1, "R3 big byte 1 = 45");
    access(LDB, 10'd0, 32'h0, 1'b1, 1'b1, "R3 big byte 0 = 23");
    access(LDB, 10'd3, 32'h0, 1'b0, 1'b1, "R2 little byte 3 = 23");
    access(LDW, 10'd0, 32'h0, 1'b1, 1'b1, "R10 word read big");
    access(STW, 10'd4, 32'h11223344, 1'b1, 1'b1, "R10 store word big");
    access(LDW, 10'd4, 32'h0, 1'b0, 1'b1, "R10 word read little");
    access(STW, 10'h3FC, 32'hDEADBEEF, 1'b0, 1'b1, "R1 store top word");
    access(LDW, 10'h3FC, 32'h0, 1'b0, 1'b1, "R1 load top word");

    // R4: sign extension
    access(STW, 10'd8, 32'h80FF7F01, 1'b0, 1'b1, "R4 store");
    access(LDB, 10'd11, 32'h0, 1'b0, 1'b1, "R4 little byte 3 negative");
    access(LDB, 10'd9, 32'h0, 1'b0, 1'b1, "R4 little byte 1 positive");
    access(LDB, 10'd10, 32'h0, 1'b0, 1'b1, "R4 little byte 2 all ones");
    access(LDB, 10'd8, 32'h0, 1'b1, 1'b1, "R4 big byte 0 negative");
    access(LDB, 10'd11, 32'h0, 1'b1, 1'b1, "R3 big byte 3 = 01");

    // R5: byte stores touch one lane
    access(STW, 10'd12, 32'h00000000, 1'b0, 1'b1, "R5 clear word");
    access(STB, 10'd13, 32'hFFFFFFAA, 1'b0, 1'b1, "R5 little byte store");
    access(STB, 10'd13, 32'h000000BB, 1'b1, 1'b1, "R5 big byte store");
    access(STB, 10'd12, 32'h123456CC, 1'b0, 1'b1, "R5 low bits only");
    access(LDW, 10'd12, 32'h0, 1'b0, 1'b1, "R5 word after byte stores");
    access(STB, 10'h3FF, 32'h00000077, 1'b1, 1'b1, "R5 big byte store top");
    access(LDW, 10'h3FC, 32'h0, 1'b0, 1'b1, "R5 top word after byte store");

    // R6: misaligned word accesses
    access(STW, 10'd16, 32'h55667788, 1'b0, 1'b1, "R6 aligned store");
    access(STW, 10'd18, 32'hFFFFFFFF, 1'b0, 1'b1, "R6 misaligned store flags");
    access(LDW, 10'd16, 32'h0, 1'b0, 1'b1, "R6 no write and flag clears");
    access(LDW, 10'd17, 32'h0, 1'b1, 1'b1, "R6 misaligned load");
    access(LDB, 10'd17, 32'h0, 1'b0, 1'b1, "R6 byte access clears flag");

    // R7: enable low
    access(STW, 10'd19, 32'h0, 1'b0, 1'b1, "R7 set flag before idle");
    access(STW, 10'd16, 32'h00000000, 1'b0, 1'b0, "R7 idle store ignored");
    access(LDB, 10'd0, 32'h0, 1'b1, 1'b0, "R7 idle load holds");
    access(LDW, 10'd16, 32'h0, 1'b0, 1'b1, "R7 word unchanged");

    // R8: stores keep the last load result
    access(LDW, 10'd0, 32'h0, 1'b0, 1'b1, "R8 load");
    access(STW, 10'd20, 32'hCAFEF00D, 1'b0, 1'b1, "R8 word store holds rd");
    access(STB, 10'd21, 32'h00000001, 1'b1, 1'b1, "R8 byte store holds rd");
    access(LDW, 10'd20, 32'h0, 1'b0, 1'b1, "R8 R5 load back");

    @(negedge clk);
    en = 1'b0;
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule